// File: doc/BRIEF.md
# Level-Two Interrupt Aggregator with Routing

This block is a second-level interrupt controller. It collects one to four 32-bit words of level-sensitive interrupt sources. Each source passes through a two-flop synchroniser into a read-only status word. A writable enable word for each source word selects which sources may raise an interrupt. The enabled, pending sources are then spread across several upstream interrupt outputs. A fixed routing mask, set at build time for each output and each word, decides which sources reach that output.

There is no acknowledge path. Every source is a level, so an output stays high while any enabled, routed source is active and falls once the sources clear. A wake output goes high while any used source is both active and enabled. During suspend, software leaves the wake set in the enable words. A small register port gives word-granular access. The enable words come out of reset holding a build-time forwarding default.

Top module: `l2i_aggregator`

## Requirements
- R1: After reset, enable word w reads the build-time default slice for word w, and every upstream output and the wake output are low.
- R2: A write to byte address w*8 (the enable register of word w) stores the write data. A later read of that address returns exactly the value written.
- R3: A read of byte address w*8+4 returns the status word for word w. Bit i of that word equals source input w*32+i, delayed by two clock edges. Writes to a status address change neither status nor any enable word.
- R4: Upstream output o is a registered level. It is high one edge after any word w has a nonzero value of status AND enable AND routing mask (o,w).
- R5: A source whose enable bit is clear raises no upstream output and does not raise the wake output.
- R6: An active, enabled source raises only those outputs whose routing mask has a one at its bit position.
- R7: A source bit that is zero in the routing masks of all outputs is unused. It never raises any output or the wake output, although it still shows in status.
- R8: The wake output is high one edge after any used source has both its status bit and its enable bit set.
- R9: A read is returned as zero, and a write has no effect, in either of two cases. The first is an address whose word index (bits 4:3) is not below the configured word count. The second is an address whose bits 1:0 are nonzero.
- R10: When the sources of an output drop, the output falls by itself, with no acknowledge, three edges after the input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_WORDS*32 | Level-sensitive interrupt sources; bit w*32+i is source i of word w |
| reg_wr_i | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr_i | input | 5 | Byte address: bits 4:3 word index, bit 2 selects status (1) or enable (0) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | NUM_OUTS | Upstream interrupt levels, one per routing mask set |
| wake_o | output | 1 | Wake request level |

## Verification
A source change driven between edges shows in status two edges later and on the outputs and wake three edges later. The bench samples status shortly after the second edge and the outputs after the third. It also samples one edge early, to confirm that nothing arrives before it is due. An enable write takes effect at its own edge, so its readback is checked straight after that edge. The outputs move one edge later, and the bench checks the output both at the write edge and at the following one. Reads are combinational, so each read is sampled a moment after the address settles, away from any clock edge.

// File: rtl/l2i_pkg.sv
package l2i_pkg;
  localparam int WORD_W    = 32;
  localparam int MAX_WORDS = 4;
  localparam int ADDR_W    = 5;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/l2i_rst_sync.sv
module l2i_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/l2i_sync.sv
module l2i_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/l2i_regs.sv
module l2i_regs
  import l2i_pkg::*;
#(
  parameter int                            NUM_WORDS = 2,
  parameter logic [NUM_WORDS*WORD_W-1:0]   FWD_MASK  = '0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  word_t                         wdata_i,
  input  logic [NUM_WORDS*WORD_W-1:0]   status_i,
  output logic [NUM_WORDS*WORD_W-1:0]   enable_o,
  output word_t                         rdata_o
);
  localparam int TOT = NUM_WORDS * WORD_W;

  logic [1:0]           widx;
  logic                 sel_stat;
  logic                 hit;
  logic [NUM_WORDS-1:0] load;
  logic [TOT-1:0]       en_q;
  logic [TOT-1:0]       en_d;

  assign widx     = addr_i[4:3];
  assign sel_stat = addr_i[2];
  assign hit      = (addr_i[1:0] == 2'b00) && ({1'b0, widx} < 3'(NUM_WORDS));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign load[w] = wr_i && hit && !sel_stat && (widx == 2'(w));
    assign en_d[w*WORD_W +: WORD_W] = wdata_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      en_q[w*WORD_W +: WORD_W] <= FWD_MASK[w*WORD_W +: WORD_W];
      else if (load[w]) en_q[w*WORD_W +: WORD_W] <= en_d[w*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (hit && (widx == 2'(w))) begin
        rdata_o = sel_stat ? status_i[w*WORD_W +: WORD_W] : en_q[w*WORD_W +: WORD_W];
      end
    end
  end

  assign enable_o = en_q;
endmodule

// File: rtl/l2i_route.sv
module l2i_route
  import l2i_pkg::*;
#(
  parameter int                                    NUM_WORDS  = 2,
  parameter int                                    NUM_OUTS   = 2,
  parameter logic [NUM_OUTS*NUM_WORDS*WORD_W-1:0]  ROUTE_MASK = '1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_WORDS*WORD_W-1:0]  status_i,
  input  logic [NUM_WORDS*WORD_W-1:0]  enable_i,
  output logic [NUM_OUTS-1:0]          irq_o,
  output logic                         wake_o
);
  localparam int TOT = NUM_WORDS * WORD_W;

  logic [TOT-1:0]      live;
  logic [TOT-1:0]      used;
  logic [NUM_OUTS-1:0] irq_d;
  logic [NUM_OUTS-1:0] irq_q;
  logic                wake_d;
  logic                wake_q;

  assign live = status_i & enable_i;

  always_comb begin
    used = '0;
    for (int o = 0; o < NUM_OUTS; o++) begin
      used = used | ROUTE_MASK[o*TOT +: TOT];
    end
  end

  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
    logic [NUM_WORDS-1:0] word_hit;
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
      assign word_hit[w] = |(live[w*WORD_W +: WORD_W] &
                             ROUTE_MASK[(o*NUM_WORDS + w)*WORD_W +: WORD_W]);
    end
    assign irq_d[o] = |word_hit;
  end

  assign wake_d = |(live & used);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      wake_q <= wake_d;
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/l2i_aggregator.sv
module l2i_aggregator
  import l2i_pkg::*;
#(
  parameter int                                    NUM_WORDS  = 2,
  parameter int                                    NUM_OUTS   = 2,
  parameter logic [NUM_WORDS*WORD_W-1:0]           FWD_MASK   = '0,
  parameter logic [NUM_OUTS*NUM_WORDS*WORD_W-1:0]  ROUTE_MASK = '1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_WORDS*WORD_W-1:0]  src_i,
  input  logic                         reg_wr_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [WORD_W-1:0]            reg_wdata_i,
  output logic [WORD_W-1:0]            reg_rdata_o,
  output logic [NUM_OUTS-1:0]          irq_o,
  output logic                         wake_o
);
  localparam int TOT = NUM_WORDS * WORD_W;

  logic           rst_n_int;
  logic [TOT-1:0] stat_vec;
  logic [TOT-1:0] en_vec;

  l2i_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  l2i_sync #(.WIDTH(TOT)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (src_i),
    .q_o    (stat_vec)
  );

  l2i_regs #(.NUM_WORDS(NUM_WORDS), .FWD_MASK(FWD_MASK)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (stat_vec),
    .enable_o (en_vec),
    .rdata_o  (reg_rdata_o)
  );

  l2i_route #(.NUM_WORDS(NUM_WORDS), .NUM_OUTS(NUM_OUTS), .ROUTE_MASK(ROUTE_MASK)) u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .status_i (stat_vec),
    .enable_i (en_vec),
    .irq_o    (irq_o),
    .wake_o   (wake_o)
  );
endmodule

// File: rtl/l2i_aggregator_chk.sv
module l2i_aggregator_chk
  import l2i_pkg::*;
#(
  parameter int                                    NUM_WORDS  = 2,
  parameter int                                    NUM_OUTS   = 2,
  parameter logic [NUM_OUTS*NUM_WORDS*WORD_W-1:0]  ROUTE_MASK = '1
) (
  input logic                         clk_i,
  input logic                         rst_n,
  input logic                         reg_wr_i,
  input logic [ADDR_W-1:0]            reg_addr_i,
  input logic [WORD_W-1:0]            reg_wdata_i,
  input logic [WORD_W-1:0]            reg_rdata_o,
  input logic [NUM_WORDS*WORD_W-1:0]  status,
  input logic [NUM_WORDS*WORD_W-1:0]  enable,
  input logic [NUM_OUTS-1:0]          irq_o,
  input logic                         wake_o
);
  localparam int TOT = NUM_WORDS * WORD_W;

  logic [NUM_OUTS-1:0] exp_irq;
  logic                exp_wake;
  logic                bad_addr;

  always_comb begin
    logic [TOT-1:0] any_route;
    any_route = '0;
    exp_irq   = '0;
    for (int o = 0; o < NUM_OUTS; o++) begin
      any_route  = any_route | ROUTE_MASK[o*TOT +: TOT];
      exp_irq[o] = |(status & enable & ROUTE_MASK[o*TOT +: TOT]);
    end
    exp_wake = |(status & enable & any_route);
  end

  assign bad_addr = (reg_addr_i[1:0] != 2'b00) || ({1'b0, reg_addr_i[4:3]} >= 3'(NUM_WORDS));

  AST_IRQ_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o == $past(exp_irq)); // R4

  AST_WAKE_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_n)
    wake_o == $past(exp_wake)); // R8

  AST_STATUS_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i[2]) |=> $stable(enable)); // R3

  AST_BAD_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_wr_i && bad_addr) |=> $stable(enable)); // R9

  AST_BAD_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    bad_addr |-> (reg_rdata_o == '0)); // R9

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wr
    AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == 5'(w*8)) |=> (enable[w*WORD_W +: WORD_W] == $past(reg_wdata_i))); // R2
  end
endmodule

bind l2i_aggregator l2i_aggregator_chk #(
  .NUM_WORDS  (NUM_WORDS),
  .NUM_OUTS   (NUM_OUTS),
  .ROUTE_MASK (ROUTE_MASK)
) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n_int),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .status      (stat_vec),
  .enable      (en_vec),
  .irq_o       (irq_o),
  .wake_o      (wake_o)
);

// File: tb/l2i_aggregator_bench.sv
module l2i_aggregator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 2;
  localparam int NO = 2;
  localparam logic [NW*32-1:0] FWD = {32'h1234_0000, 32'h0000_00A5};
  // order: {out1 word1, out1 word0, out0 word1, out0 word0}
  localparam logic [NO*NW*32-1:0] ROUTE = {32'h0000_FF00, 32'hFFFF_0000,
                                           32'h0000_00FF, 32'h0000_FFFF};

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NW*32-1:0] src;
  logic            wr;
  logic [4:0]      addr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic [NO-1:0]   irq;
  logic            wake;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2i_aggregator #(.NUM_WORDS(NW), .NUM_OUTS(NO), .FWD_MASK(FWD), .ROUTE_MASK(ROUTE)) u_l2i_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic drive_src(input logic [NW*32-1:0] v);
    @(negedge clk);
    src = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(5'h00, d); check("R1 enable w0 default", d, 32'h0000_00A5);
    reg_read(5'h08, d); check("R1 enable w1 default", d, 32'h1234_0000);
    check("R1 irq low", {30'b0, irq}, 32'h0);
    check("R1 wake low", {31'b0, wake}, 32'h0);
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    reg_write(5'h00, 32'hDEAD_BEEF);
    reg_read(5'h00, d); check("R2 enable w0 readback", d, 32'hDEAD_BEEF);
    reg_write(5'h08, 32'h0F0F_5AA5);
    reg_read(5'h08, d); check("R2 enable w1 readback", d, 32'h0F0F_5AA5);
    reg_read(5'h00, d); check("R2 enable w0 untouched", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_status();
    logic [31:0] d;
    reg_write(5'h00, 32'h0);
    reg_write(5'h08, 32'h0);
    @(negedge clk);
    src = {32'h8000_0001, 32'h1357_9BDF};
    @(posedge clk); #1;
    reg_read(5'h04, d); check("R3 status not yet after one edge", d, 32'h0);
    @(posedge clk); #1;
    reg_read(5'h04, d); check("R3 status w0 after two edges", d, 32'h1357_9BDF);
    reg_read(5'h0C, d); check("R3 status w1 after two edges", d, 32'h8000_0001);
    reg_write(5'h04, 32'hFFFF_FFFF);
    reg_read(5'h04, d); check("R3 status unchanged by write", d, 32'h1357_9BDF);
    reg_read(5'h00, d); check("R3 enable unchanged by status write", d, 32'h0);
    check("R5 disabled sources raise no irq", {30'b0, irq}, 32'h0);
    check("R5 disabled sources raise no wake", {31'b0, wake}, 32'h0);
    drive_src('0);
  endtask

  task automatic t_route();
    reg_write(5'h00, 32'hFFFF_FFFF);
    reg_write(5'h08, 32'hFFFF_FFFF);
    @(negedge clk);
    src = {32'h0, 32'h0000_0008};
    repeat (2) @(posedge clk); #1;
    check("R4 irq not yet after two edges", {30'b0, irq}, 32'h0);
    @(posedge clk); #1;
    check("R6 w0 bit3 to out0 only", {30'b0, irq}, 32'h1);
    check("R8 wake for used source", {31'b0, wake}, 32'h1);
    drive_src({32'h0, 32'h0010_0000});
    check("R6 w0 bit20 to out1 only", {30'b0, irq}, 32'h2);
    drive_src({32'h0000_0200, 32'h0});
    check("R6 w1 bit9 to out1 only", {30'b0, irq}, 32'h2);
    drive_src({32'h0000_0004, 32'h0});
    check("R6 w1 bit2 to out0 only", {30'b0, irq}, 32'h1);
    drive_src({32'h0000_0004, 32'h0010_0000});
    check("R6 both outputs", {30'b0, irq}, 32'h3);
    drive_src('0);
    check("R10 irq falls without ack", {30'b0, irq}, 32'h0);
    check("R10 wake falls", {31'b0, wake}, 32'h0);
  endtask

  task automatic t_mask();
    reg_write(5'h00, 32'hFFFF_FFF7);
    drive_src({32'h0, 32'h0000_0008});
    check("R5 masked bit3 no irq", {30'b0, irq}, 32'h0);
    check("R5 masked bit3 no wake", {31'b0, wake}, 32'h0);
    reg_write(5'h00, 32'h0000_0008);
    check("R4 irq not at enable write edge", {30'b0, irq}, 32'h0);
    @(posedge clk); #1;
    check("R4 irq one edge after enable", {30'b0, irq}, 32'h1);
    reg_write(5'h00, 32'h0);
    @(posedge clk); #1;
    check("R5 irq drops after mask", {30'b0, irq}, 32'h0);
    drive_src('0);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    reg_write(5'h00, 32'hFFFF_FFFF);
    reg_write(5'h08, 32'hFFFF_FFFF);
    drive_src({32'hFFFF_0000, 32'h0});
    check("R7 unused sources no irq", {30'b0, irq}, 32'h0);
    check("R7 unused sources no wake", {31'b0, wake}, 32'h0);
    reg_read(5'h0C, d); check("R7 unused still in status", d, 32'hFFFF_0000);
    drive_src('0);
  endtask

  task automatic t_range();
    logic [31:0] d;
    reg_write(5'h00, 32'hCAFE_0001);
    reg_write(5'h08, 32'h0BAD_F00D);
    reg_write(5'h10, 32'hFFFF_FFFF);
    reg_write(5'h01, 32'h1111_1111);
    reg_read(5'h10, d); check("R9 read beyond words zero", d, 32'h0);
    reg_read(5'h1C, d); check("R9 read last address zero", d, 32'h0);
    reg_read(5'h02, d); check("R9 misaligned read zero", d, 32'h0);
    reg_read(5'h00, d); check("R9 w0 unchanged by bad writes", d, 32'hCAFE_0001);
    reg_read(5'h08, d); check("R9 w1 unchanged by bad writes", d, 32'h0BAD_F00D);
  endtask

  initial begin
    rst_n = 1'b0; src = '0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_enable_rw();
    t_status();
    t_route();
    t_mask();
    t_unused();
    t_range();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule